// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of the array of a pipelined synchronous burst memory and turns one captured start address into the four word addresses of a burst. A burst begins when either of two active-low address strobes is sampled low on a rising clock edge. One strobe comes from the processor and one from the cache controller. The full external address is then registered. Later edges with the active-low advance input low step a two-bit counter. That counter alters only the two lowest address bits.

A static order input picks the walk through the four positions. In linear order the low bits count up modulo four from the start value. In interleaved order the low bits are the start value XOR the count. The processor strobe only acts while the active-low chip select is low. The controller strobe acts regardless of chip select. The counter wraps without stopping. A `loaded` flag marks the first cycle of each new burst. An `active` flag shows that at least one burst has started since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `word_addr` = 0, `loaded` = 0 and `active` = 0.
- R2: When `ctrl_as_n` is low at a rising edge, `addr_in` is captured whatever the level of `cs_n`. After that edge, `word_addr` equals the captured address, `loaded` = 1 and `active` = 1.
- R3: `proc_as_n` low captures `addr_in` only when `cs_n` is low at the same edge. With `cs_n` high, a low `proc_as_n` leaves `word_addr` unchanged and `loaded` at 0.
- R4: With no accepted strobe, the burst position steps by one only on edges where `adv_n` is low. On other edges `word_addr` holds, and `loaded` drops to 0 after any edge without a load.
- R5: Within a burst, `word_addr[ADDR_W-1:2]` keeps the value captured at the start.
- R6: With `ilv_order` = 0 (linear), after k advances the low two bits are (start + k) mod 4.
- R7: With `ilv_order` = 1 (interleaved), after k advances the low two bits are start XOR (k mod 4). For example, a start of 2 gives 2, 3, 0, 1.
- R8: An accepted strobe takes priority over `adv_n`. This holds also when both strobes are low together. The new address loads and the count returns to position 0.
- R9: After four advances the sequence is back at the start address and keeps going.
- R10: Before the first accepted strobe after reset, `adv_n` low has no effect: `word_addr` stays 0 and `active` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| proc_as_n | input | 1 | Processor address strobe, active low, gated by `cs_n` |
| ctrl_as_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Primary chip select, active low |
| ilv_order | input | 1 | Static order select: 0 linear, 1 interleaved |
| word_addr | output | ADDR_W | Current word address to the array |
| loaded | output | 1 | High for the cycle after a new start address was captured |
| active | output | 1 | High once any burst has started since reset |

## Verification
The bench builds the sequencer with `ADDR_W` = 12. With that width the upper field is ten bits wide, so nonzero upper patterns can be spread across it. Any carry or borrow leaking out of the two-bit counter then shows up as a visible change above bit 1. The bench starts bursts from each low-bit value in both orders and runs past four advances to reach the wrap. It also applies strobes during an advance, both strobes together, and a processor strobe with chip select high.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_as_n,
  input  logic              ctrl_as_n,
  input  logic              adv_n,
  input  logic              cs_n,
  input  logic              ilv_order,
  output logic [ADDR_W-1:0] word_addr,
  output logic              loaded,
  output logic              active
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              loaded_q;
  logic              active_q;
  logic              start;
  logic              step;
  logic [CNT_W-1:0]  low_lin;
  logic [CNT_W-1:0]  low_ilv;

  assign start = ~ctrl_as_n | (~proc_as_n & ~cs_n);
  assign step  = ~adv_n & active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      active_q <= 1'b0;
    end else if (start) begin
      base_q   <= addr_in;
      cnt_q    <= '0;
      loaded_q <= 1'b1;
      active_q <= 1'b1;
    end else begin
      loaded_q <= 1'b0;
      if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low_lin   = base_q[CNT_W-1:0] + cnt_q;
  assign low_ilv   = base_q[CNT_W-1:0] ^ cnt_q;
  assign word_addr = {base_q[ADDR_W-1:CNT_W], ilv_order ? low_ilv : low_lin};
  assign loaded    = loaded_q;
  assign active    = active_q;
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_as_n,
  input logic              ctrl_as_n,
  input logic              adv_n,
  input logic              cs_n,
  input logic              ilv_order,
  input logic [ADDR_W-1:0] word_addr,
  input logic              loaded,
  input logic              active
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_as_n |=> (word_addr == $past(addr_in)) && loaded && active);

  // R3
  proc_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_as_n && cs_n && ctrl_as_n && adv_n) |=> $stable(word_addr) && !loaded);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_as_n && (proc_as_n || cs_n) && adv_n) |=> $stable(word_addr));

  // R5
  upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_as_n && (proc_as_n || cs_n)) |=> $stable(word_addr[ADDR_W-1:2]));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !adv_n && ctrl_as_n && (proc_as_n || cs_n) && !ilv_order)
      |=> word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1));

  // R10
  idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && ctrl_as_n && (proc_as_n || cs_n)) |=> !active && $stable(word_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .proc_as_n(proc_as_n),
  .ctrl_as_n(ctrl_as_n), .adv_n(adv_n), .cs_n(cs_n), .ilv_order(ilv_order),
  .word_addr(word_addr), .loaded(loaded), .active(active)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_as_n = 1'b1, ctrl_as_n = 1'b1, adv_n = 1'b1, cs_n = 1'b1;
  logic          ilv_order = 1'b0;
  logic [AW-1:0] word_addr;
  logic          loaded, active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_base = 0, m_cnt = 0;
  bit m_loaded = 0, m_active = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_as_n(proc_as_n),
    .ctrl_as_n(ctrl_as_n), .adv_n(adv_n), .cs_n(cs_n), .ilv_order(ilv_order),
    .word_addr(word_addr), .loaded(loaded), .active(active)
  );

  function automatic int exp_addr();
    int lo;
    if (ilv_order) lo = (m_base & 3) ^ m_cnt;
    else           lo = ((m_base & 3) + m_cnt) % 4;
    return (m_base & ~3) | lo;
  endfunction

  task automatic model_edge();
    bit st;
    st = !ctrl_as_n || (!proc_as_n && !cs_n);
    if (rst) begin
      m_base = 0; m_cnt = 0; m_loaded = 0; m_active = 0;
    end else if (st) begin
      m_base = int'(addr_in); m_cnt = 0; m_loaded = 1; m_active = 1;
    end else begin
      m_loaded = 0;
      if (!adv_n && m_active) m_cnt = (m_cnt + 1) % 4;
    end
  endtask

  task automatic step(input string tag, input bit r, input bit pa, input bit ca,
                      input bit av, input bit cs, input int a);
    rst = r; proc_as_n = pa; ctrl_as_n = ca; adv_n = av; cs_n = cs;
    addr_in = AW'(a);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (int'(word_addr) != exp_addr() || loaded != m_loaded || active != m_active) begin
      errors++;
      $display("FAIL %s addr=%h/%h loaded=%0d/%0d active=%0d/%0d (got/exp)",
               tag, word_addr, AW'(exp_addr()), loaded, m_loaded, active, m_active);
    end
  endtask

  task automatic idle(input string tag);  step(tag, 0, 1, 1, 1, 1, 12'h000); endtask
  task automatic adv(input string tag);   step(tag, 0, 1, 1, 0, 1, 12'h000); endtask
  task automatic cload(input string tag, input int a); step(tag, 0, 1, 0, 1, 1, a); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1", 1, 0, 0, 0, 0, 12'hFFF);
    step("R1", 1, 1, 1, 1, 1, 12'h555);
    adv("R10"); adv("R10"); idle("R10");

    for (int o = 0; o < 2; o++) begin
      step("R1", 1, 1, 1, 1, 1, 0);
      ilv_order = o[0];
      for (int s = 0; s < 4; s++) begin
        cload("R2", 12'hA50 | s);
        for (int k = 0; k < 6; k++) adv(o ? "R7 R9" : "R6 R9");
        idle("R4"); idle("R5");
        adv(o ? "R7" : "R6");
      end
      step("R3", 0, 0, 1, 1, 1, 12'h3C1);
      step("R3", 0, 0, 1, 0, 1, 12'h3C1);
      step("R3", 0, 0, 1, 1, 0, 12'h3C1);
      adv("R4");
      step("R8", 0, 1, 0, 0, 1, 12'h7F3);
      adv("R8");
      step("R8", 0, 0, 0, 0, 0, 12'h812);
      adv("R8"); adv("R8");
      step("R2", 0, 1, 0, 0, 1, 12'hFFF);
      for (int k = 0; k < 5; k++) adv("R5 R9");
      step("R8", 0, 0, 1, 0, 0, 12'h001);
      adv("R4"); idle("R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule